// File: doc/BRIEF.md
# Switch-Selected Musical Note Generator

This block turns a bank of seven switches into an audio tone for a 12-bit DAC channel. Each switch owns one pitch of the C-major scale from middle C upward (C4 to B4). While a switch is on, the block plays a square wave at that pitch. The wave alternates between a fixed high amplitude code and a fixed low amplitude code, placed symmetrically about mid-scale.

The block runs from the system clock. Each note has its own half-period divider, derived at elaboration from the clock frequency. The 12-bit output register only changes on a sample strobe, so a downstream converter that reads at the audio sample rate always sees a settled code. When several switches are on, one note is chosen by a fixed priority. When no switch is on, the output rests at mid-scale, so the speaker does not click.

Top module: `note_tone_gen`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first sample update, `dac_o` is 12'h800.
- R2: `dac_o` may change only on the clock edge that ends each sample period of CLK_HZ/SAMPLE_HZ clocks, counted from reset release. It holds its value on all other edges.
- R3: `sw_i[0]` through `sw_i[6]` select C 261.626 Hz, D 293.665 Hz, E 329.628 Hz, F 349.228 Hz, G 391.995 Hz, A 440.000 Hz and B 493.883 Hz, in that order. The selected note's square wave changes level every round(CLK_HZ / (2 × f_note)) clocks.
- R4: While a note is selected, the output code is 12'hC00 in the high half of the wave and 12'h400 in the low half.
- R5: With no switch on, the output settles to 12'h800 at the next sample update.
- R6: With several switches on, the lowest-indexed active switch decides the note. Higher-indexed active switches have no effect on the output.
- R7: When the selected note changes, or becomes selected from idle, its divider restarts. The wave begins with a full-length high half-period.
- R8: `dac_o` only ever holds 12'h400, 12'h800 or 12'hC00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_i | input | 7 | Note switches; bit 0 is C, bit 6 is B |
| dac_o | output | 12 | Amplitude code for the DAC channel, updated once per sample period |

## Verification
A switch value is latched on the first rising edge after it is driven. The divider of a newly selected note restarts on that same edge. The result reaches `dac_o` on the next edge that ends a sample period, so the latency is between one clock and one sample period plus one clock. The bench keeps its own per-clock reference of the sample counter, the latched selection and the clocks elapsed since selection, and updates it on every rising edge. It compares `dac_o` on every falling edge. Each comparison is tagged by whether the edge was a hold edge or an update edge, and by what the selection was just before that update.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned NOTE_COUNT = 7;
  localparam int unsigned DAC_W      = 12;

  localparam logic [DAC_W-1:0] CODE_HI  = 12'hC00;
  localparam logic [DAC_W-1:0] CODE_LO  = 12'h400;
  localparam logic [DAC_W-1:0] CODE_MID = 12'h800;

  // pitch in millihertz, index 0 = C4 .. 6 = B4
  function automatic int unsigned note_mhz(input int unsigned idx);
    case (idx)
      0:       return 261626;
      1:       return 293665;
      2:       return 329628;
      3:       return 349228;
      4:       return 391995;
      5:       return 440000;
      default: return 493883;
    endcase
  endfunction

  // rounded clocks per half period
  function automatic int unsigned half_cycles(input int unsigned clk_hz, input int unsigned idx);
    longint unsigned num, den;
    num = longint'(clk_hz) * 64'd1000;
    den = 64'd2 * longint'(note_mhz(idx));
    return int'((num + den / 2) / den);
  endfunction
endpackage

// File: rtl/tone_strobe.sv
module tone_strobe #(
  parameter int unsigned DIV = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/note_pick.sv
module note_pick #(
  parameter int unsigned N = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         sw_i,
  output logic                 vld_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] pick;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sw_i[i]) pick = IW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      idx_o <= '0;
    end else begin
      vld_o <= |sw_i;
      idx_o <= pick;
    end
  end
endmodule

// File: rtl/note_divider.sv
module note_divider #(
  parameter int unsigned HALF = 191113
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic phase_o
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt_q;

  // idle divider parks at count 0, high phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q   <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/note_tone_gen.sv
module note_tone_gen
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned SAMPLE_HZ = 20_000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NOTE_COUNT-1:0] sw_i,
  output logic [DAC_W-1:0]      dac_o
);
  localparam int unsigned SDIV = CLK_HZ / SAMPLE_HZ;
  localparam int unsigned IW   = $clog2(NOTE_COUNT);

  logic                  tick;
  logic                  sel_vld;
  logic [IW-1:0]         sel_idx;
  logic [NOTE_COUNT-1:0] phase;
  logic [DAC_W-1:0]      code;

  tone_strobe #(.DIV(SDIV)) u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  note_pick #(.N(NOTE_COUNT)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sw_i  (sw_i),
    .vld_o (sel_vld),
    .idx_o (sel_idx)
  );

  for (genvar g = 0; g < NOTE_COUNT; g++) begin : g_note
    note_divider #(.HALF(half_cycles(CLK_HZ, g))) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (sel_vld && (sel_idx == IW'(g))),
      .phase_o(phase[g])
    );
  end

  always_comb begin
    if (!sel_vld)            code = CODE_MID;
    else if (phase[sel_idx]) code = CODE_HI;
    else                     code = CODE_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dac_o <= CODE_MID;
    else if (tick) dac_o <= code;
  end
endmodule

// File: rtl/note_tone_chk.sv
module note_tone_chk
  import tone_pkg::*;
#(
  parameter int unsigned SDIV = 5000
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NOTE_COUNT-1:0] sw_i,
  input logic [DAC_W-1:0]      dac_o
);
  localparam int unsigned W = (SDIV > 1) ? $clog2(SDIV) : 1;
  localparam logic [W-1:0] LAST = W'(SDIV - 1);

  logic [W-1:0] c_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          c_q <= '0;
    else if (c_q == LAST) c_q <= '0;
    else                  c_q <= c_q + W'(1);
  end

  function automatic logic [NOTE_COUNT-1:0] low_bit(input logic [NOTE_COUNT-1:0] x);
    return x & (~x + NOTE_COUNT'(1));
  endfunction

  a_r8_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_o == CODE_MID) || (dac_o == CODE_HI) || (dac_o == CODE_LO));

  a_r2_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q != LAST) |=> $stable(dac_o));

  a_r5_idle_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q == LAST && $past(sw_i) == '0) |=> (dac_o == CODE_MID));

  a_r4_active_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q == LAST && $past(sw_i) != '0) |=> (dac_o != CODE_MID));

  a_r7_fresh_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_q == LAST && low_bit($past(sw_i)) != '0
     && low_bit($past(sw_i)) != low_bit($past(sw_i, 2))) |=> (dac_o == CODE_HI));
endmodule

bind note_tone_gen note_tone_chk #(.SDIV(CLK_HZ / SAMPLE_HZ)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sw_i  (sw_i),
  .dac_o (dac_o)
);

// File: tb/sim_note_tone_gen.sv
`timescale 1ns/1ps
module sim_note_tone_gen;
  localparam int unsigned CLK_HZ     = 200_000;
  localparam int unsigned SAMPLE_HZ  = 20_000;
  localparam int unsigned SDIV       = CLK_HZ / SAMPLE_HZ;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk   = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  sw    = '0;
  logic [11:0] dac;

  note_tone_gen #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SAMPLE_HZ)) u0 (
    .clk_i (clk),
    .rst_ni(rst_n),
    .sw_i  (sw),
    .dac_o (dac)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // R3: pitch table and rounding
  function automatic int unsigned exp_half(input int unsigned idx);
    real f;
    case (idx)
      0: f = 261.626; 1: f = 293.665; 2: f = 329.628; 3: f = 349.228;
      4: f = 391.995; 5: f = 440.000; default: f = 493.883;
    endcase
    return int'($rtoi(real'(CLK_HZ) / (2.0 * f) + 0.5));
  endfunction

  // reference state
  logic        m_vld = 1'b0;
  int unsigned m_idx = 0;
  int unsigned m_k = 0;
  int unsigned m_tcnt = 0;
  logic [6:0]  m_sw = '0;
  logic [11:0] m_exp = 12'h800;
  logic        m_upd = 1'b0;
  string       m_tag = "R1 after reset";

  always @(posedge clk) begin : ref_model
    logic [11:0] lvl;
    logic        n_vld;
    int unsigned n_idx;
    if (!rst_n) begin
      m_vld <= 1'b0; m_idx <= 0; m_k <= 0; m_tcnt <= 0; m_sw <= '0;
      m_exp <= 12'h800; m_upd <= 1'b0; m_tag <= "R1 after reset";
    end else begin
      if (!m_vld) lvl = 12'h800;
      else if (((m_k / exp_half(m_idx)) % 2) == 0) lvl = 12'hC00;
      else lvl = 12'h400;
      if (m_tcnt == SDIV - 1) begin
        m_tcnt <= 0;
        m_upd  <= 1'b1;
        m_exp  <= lvl;
        if (!m_vld)                    m_tag <= "R5 idle mid-scale";
        else if ($countones(m_sw) > 1) m_tag <= "R6 lowest note wins";
        else if (m_k < exp_half(m_idx)) m_tag <= "R7 fresh first half high";
        else                           m_tag <= "R3 R4 pitch and levels";
      end else begin
        m_tcnt <= m_tcnt + 1;
        m_upd  <= 1'b0;
      end
      n_vld = |sw;
      n_idx = 0;
      for (int i = 6; i >= 0; i--) if (sw[i]) n_idx = i;
      if (n_vld && (!m_vld || n_idx != m_idx)) m_k <= 0;
      else m_k <= m_k + 1;
      m_vld <= n_vld;
      m_idx <= n_idx;
      m_sw  <= sw;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) chk("R1 reset value", dac, 12'h800);
    else begin
      if (!m_upd) chk("R2 hold between updates", dac, m_exp);
      else        chk(m_tag, dac, m_exp);
      if (dac != 12'h800 && dac != 12'hC00 && dac != 12'h400)
        chk("R8 legal code", dac, 12'h800);
    end
  end

  task automatic hold(input logic [6:0] v, input int unsigned n);
    @(negedge clk); #1;
    sw = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20260);
    sw = 7'h55;                       // R1: switches ignored in reset
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1; sw = '0;
    hold(7'h00, 200);                 // R5
    for (int i = 0; i < 7; i++)       // R3 R4 each note alone
      hold(7'(1 << i), 3 * exp_half(i) + 40);
    hold(7'h7F, 900);                 // R6
    hold(7'h60, 700);
    hold(7'h41, 500);
    hold(7'h01, 150);                 // R7 restart mid half-period
    hold(7'h02, 150);
    hold(7'h01, 500);
    hold(7'h03, 300);                 // adding higher switch keeps phase
    hold(7'h00, 40);
    hold(7'h08, 23);
    @(negedge clk); #1 rst_n = 1'b0; sw = 7'h08;  // R1 mid-run reset
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    hold(7'h08, 600);
    for (int p = 0; p < 60; p++) begin
      int unsigned kind;
      logic [6:0]  v;
      kind = $urandom_range(0, 3);
      case (kind)
        0:       v = '0;
        1:       v = 7'(1 << $urandom_range(0, 6));
        default: v = 7'($urandom());
      endcase
      hold(v, $urandom_range(5, 1200));
    end
    hold(7'h00, 30);
    finish_run();
  end
endmodule